// File: doc/BRIEF.md
# Serial Command Host for a Dual Current-Sink DAC

This block sits on the host side of a three-wire serial link to a dual current-sink DAC. A client hands it a 4-bit opcode and a 10-bit code over a valid/ready handshake. The block turns that request into one 16-bit command frame and shifts it out on chip select, serial clock and serial data. The opcode goes out first, then the code with its most significant bit leading, then two zero pad bits. The receiver takes each bit on a falling clock edge. Data therefore changes only on rising edges, or when chip select drops.

The serial clock comes from the system clock through programmable high-phase and low-phase cycle counts. Separate counters set three intervals: how long chip select stays low before the first falling edge, how long it stays low after the last falling edge, and how long it stays high between frames. Each interval is given in system-clock cycles. An elaboration-time check rejects any set of counts that would break the nanosecond minimums at the stated clock period.

A parameter picks the level the clock rests at, low or high. Either way, the frame content and the falling-edge sampling stay the same. Once chip select has gone high and the minimum high time has passed, the block pulses `done` for one cycle and raises `req_ready` again.

Top module: `dac_cmd_spi_host`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `spi_cs_n` is 1, `spi_sck` sits at the selected idle level, `req_ready` is 1 and `done` is 0.
- R2: Each frame contains exactly 16 falling edges of `spi_sck` while `spi_cs_n` is low. The bits taken on those edges, in order, are req_op[3] down to req_op[0], then req_code[9] down to req_code[0], then two 0 bits.
- R3: `spi_sdo` does not change for at least 40 ns (8 cycles at 5 ns) before each falling edge of `spi_sck` within a frame. It never changes on the falling edge itself.
- R4: Within a frame, every high phase and every low phase of `spi_sck` lasts at least 40 ns. The time from one falling edge to the next is at least 100 ns.
- R5: At least 25 ns pass between the fall of `spi_cs_n` and the first falling edge of `spi_sck`.
- R6: At least 50 ns pass between the last falling edge of `spi_sck` and the rise of `spi_cs_n`.
- R7: Between two frames, `spi_cs_n` stays high for at least 100 ns. `done` is a single-cycle pulse, issued once per frame, and only after `spi_cs_n` has been high for at least 100 ns.
- R8: A request is taken only in a cycle where `req_ready` is 1, and `req_ready` is 0 for the whole time a frame is in progress. Opcode and code are captured at acceptance, so later changes to the request inputs, including a held `req_valid`, have no effect on the frame in progress.
- R9: Whenever `spi_cs_n` is high, `spi_sck` equals the IDLE_HIGH parameter (0 = rests low, 1 = rests high). Both settings deliver the same frame content.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_op | input | 4 | Command opcode, sent first |
| req_code | input | 10 | DAC code, sent after the opcode, MSB first |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_sck | output | 1 | Serial clock |
| spi_sdo | output | 1 | Serial data to the DAC |
| done | output | 1 | One-cycle pulse when a frame and its chip-select high time are complete |

## Verification
The bench runs a cycle-accurate receiver against two instances at once, one resting the clock low and one resting it high. It sweeps every opcode against codes at the ends and middle of the range, then walks a single one across the code field. Every frame is checked: the decoded word, the edge count, and every interval measured in cycles.

Each class of bug shows up in a specific check:
- A design that shifts on the wrong edge, or forgets the first shift, shows up as a wrong word.
- A design that measures setup from the wrong point, or cuts the hold or gap short, fails the interval checks.
- A design that raises the clock with chip select still high in the idle-high variant fails the idle-level check.
- A design that re-accepts a request held high during a busy frame delivers the wrong word or an extra frame.

// File: rtl/dsh_pkg.sv
package dsh_pkg;

    localparam int OP_W     = 4;
    localparam int CODE_W   = 10;
    localparam int PAD_W    = 2;
    localparam int FRAME_W  = OP_W + CODE_W + PAD_W;
    localparam int NFALL_W  = $clog2(FRAME_W + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_HIGH,
        ST_LOW,
        ST_HOLD,
        ST_GAP
    } dsh_state_e;

    typedef struct packed {
        dsh_state_e           state;
        logic                 cs_n;
        logic                 sck;
        logic [FRAME_W-1:0]   sr;
        logic [NFALL_W-1:0]   nfall;
        logic                 done;
    } dsh_regs_t;

    function automatic int dsh_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dsh_word_pack.sv
module dsh_word_pack
    import dsh_pkg::*;
(
    input  logic [OP_W-1:0]    op,
    input  logic [CODE_W-1:0]  code,
    output logic [FRAME_W-1:0] word
);
    // opcode leads, code MSB first, zero padding trails
    assign word = {op, code, {PAD_W{1'b0}}};
endmodule

// File: rtl/dsh_cycle_timer.sv
module dsh_cycle_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/dac_cmd_spi_host.sv
module dac_cmd_spi_host
    import dsh_pkg::*;
#(
    parameter int CLK_NS     = 5,
    parameter int SCK_HI_CYC = 10,
    parameter int SCK_LO_CYC = 10,
    parameter int CSS_CYC    = 6,
    parameter int CSH_CYC    = 11,
    parameter int CSW_CYC    = 21,
    parameter bit IDLE_HIGH  = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [OP_W-1:0]   req_op,
    input  logic [CODE_W-1:0] req_code,
    output logic              spi_cs_n,
    output logic              spi_sck,
    output logic              spi_sdo,
    output logic              done
);
    // idle-high: the first falling edge ends the setup phase, so it also
    // has to give the first bit its data setup time
    localparam int SETUP_CYC = IDLE_HIGH ? dsh_max(CSS_CYC, SCK_HI_CYC) : CSS_CYC;
    localparam int MAX_CYC   = dsh_max(dsh_max(dsh_max(SETUP_CYC, SCK_HI_CYC),
                                       dsh_max(SCK_LO_CYC, CSH_CYC)), CSW_CYC);
    localparam int TW        = $clog2(MAX_CYC + 1);
    localparam int NUM_TMR   = 3;
    localparam int T_PHASE   = 0;   // clock high/low phases
    localparam int T_EDGE    = 1;   // chip-select setup and hold
    localparam int T_GAP     = 2;   // chip-select high time

    localparam bit TIMING_OK =
        (SCK_HI_CYC >= 1) && (SCK_LO_CYC >= 1) && (CSS_CYC >= 1) &&
        (CSH_CYC >= 1) && (CSW_CYC >= 1) &&
        (SCK_HI_CYC * CLK_NS >= 40) && (SCK_LO_CYC * CLK_NS >= 40) &&
        ((SCK_HI_CYC + SCK_LO_CYC) * CLK_NS >= 100) &&
        (CSS_CYC * CLK_NS >= 25) && (CSH_CYC * CLK_NS >= 50) &&
        (CSH_CYC * CLK_NS >= 40) && (CSW_CYC * CLK_NS >= 100);

    if (!TIMING_OK) begin : g_bad_timing
        $error("dac_cmd_spi_host: interval counts violate the serial timing minimums");
    end

    localparam dsh_regs_t RST_VAL = '{
        state: ST_IDLE, cs_n: 1'b1, sck: IDLE_HIGH,
        sr: '0, nfall: '0, done: 1'b0
    };

    dsh_regs_t            r_d, r_q;
    logic [FRAME_W-1:0]   word;
    logic [NUM_TMR-1:0]   tmr_load;
    logic [NUM_TMR-1:0]   tmr_zero;
    logic [TW-1:0]        tmr_val [NUM_TMR];

    dsh_word_pack u_pack (
        .op   (req_op),
        .code (req_code),
        .word (word)
    );

    for (genvar k = 0; k < NUM_TMR; k++) begin : g_tmr
        dsh_cycle_timer #(.W(TW)) u_tmr (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (tmr_load[k]),
            .load_val (tmr_val[k]),
            .expired  (tmr_zero[k])
        );
    end

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        tmr_load = '0;
        for (int k = 0; k < NUM_TMR; k++) tmr_val[k] = '0;

        unique case (r_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.state = ST_SETUP;
                    r_d.cs_n  = 1'b0;
                    r_d.sr    = word;
                    r_d.nfall = '0;
                    tmr_load[T_EDGE] = 1'b1;
                    tmr_val[T_EDGE]  = TW'(SETUP_CYC - 1);
                end
            end
            ST_SETUP: begin
                if (tmr_zero[T_EDGE]) begin
                    if (IDLE_HIGH) begin
                        r_d.sck   = 1'b0;
                        r_d.nfall = NFALL_W'(1);
                        r_d.state = ST_LOW;
                        tmr_load[T_PHASE] = 1'b1;
                        tmr_val[T_PHASE]  = TW'(SCK_LO_CYC - 1);
                    end else begin
                        r_d.sck   = 1'b1;
                        r_d.state = ST_HIGH;
                        tmr_load[T_PHASE] = 1'b1;
                        tmr_val[T_PHASE]  = TW'(SCK_HI_CYC - 1);
                    end
                end
            end
            ST_HIGH: begin
                if (tmr_zero[T_PHASE]) begin
                    r_d.sck   = 1'b0;
                    r_d.nfall = r_q.nfall + 1'b1;
                    if (r_q.nfall == NFALL_W'(FRAME_W - 1)) begin
                        r_d.state = ST_HOLD;
                        tmr_load[T_EDGE] = 1'b1;
                        tmr_val[T_EDGE]  = TW'(CSH_CYC - 1);
                    end else begin
                        r_d.state = ST_LOW;
                        tmr_load[T_PHASE] = 1'b1;
                        tmr_val[T_PHASE]  = TW'(SCK_LO_CYC - 1);
                    end
                end
            end
            ST_LOW: begin
                if (tmr_zero[T_PHASE]) begin
                    r_d.sck   = 1'b1;
                    r_d.sr    = {r_q.sr[FRAME_W-2:0], 1'b0};
                    r_d.state = ST_HIGH;
                    tmr_load[T_PHASE] = 1'b1;
                    tmr_val[T_PHASE]  = TW'(SCK_HI_CYC - 1);
                end
            end
            ST_HOLD: begin
                if (tmr_zero[T_EDGE]) begin
                    r_d.cs_n  = 1'b1;
                    r_d.sck   = IDLE_HIGH;
                    r_d.sr    = '0;
                    r_d.state = ST_GAP;
                    tmr_load[T_GAP] = 1'b1;
                    tmr_val[T_GAP]  = TW'(CSW_CYC - 1);
                end
            end
            ST_GAP: begin
                if (tmr_zero[T_GAP]) begin
                    r_d.done  = 1'b1;
                    r_d.state = ST_IDLE;
                end
            end
            default: r_d = RST_VAL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= RST_VAL;
        else        r_q <= r_d;
    end

    assign req_ready = (r_q.state == ST_IDLE);
    assign spi_cs_n  = r_q.cs_n;
    assign spi_sck   = r_q.sck;
    assign spi_sdo   = r_q.sr[FRAME_W-1];
    assign done      = r_q.done;

endmodule

// File: rtl/dsh_spi_host_chk.sv
module dsh_spi_host_chk #(
    parameter bit IDLE_HIGH = 1'b0,
    parameter int CSW_CYC   = 21
) (
    input logic clk,
    input logic rst_n,
    input logic req_ready,
    input logic done,
    input logic spi_cs_n,
    input logic spi_sck,
    input logic spi_sdo
);
    logic [15:0] hi_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               hi_run <= '1;
        else if (!spi_cs_n)       hi_run <= '0;
        else if (hi_run != '1)    hi_run <= hi_run + 1'b1;
    end

    a_r1_reset_idle: assert property (@(posedge clk)
        $rose(rst_n) |-> (spi_cs_n && req_ready && !done && spi_sck == IDLE_HIGH));

    a_r3_sdo_stable_at_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (!spi_cs_n && $fell(spi_sck)) |-> $stable(spi_sdo));

    a_r3_sdo_moves_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (!spi_cs_n && $past(!spi_cs_n) && !$stable(spi_sdo)) |-> $rose(spi_sck));

    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r7_done_cs_high: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> spi_cs_n);

    a_r7_cs_high_min: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(spi_cs_n) |-> (int'(hi_run) >= CSW_CYC));

    a_r8_ready_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> spi_cs_n);

    a_r9_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> (spi_sck == IDLE_HIGH));

endmodule

bind dac_cmd_spi_host dsh_spi_host_chk #(
    .IDLE_HIGH (IDLE_HIGH),
    .CSW_CYC   (CSW_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .done      (done),
    .spi_cs_n  (spi_cs_n),
    .spi_sck   (spi_sck),
    .spi_sdo   (spi_sdo)
);

// File: tb/dac_cmd_spi_host_tb.sv
`timescale 1ns/1ps

module dsh_rx_mon #(
    parameter bit    IDLE_HIGH = 1'b0,
    parameter string NAME      = "mon"
) (
    input logic        clk,
    input logic        en,
    input logic        cs_n,
    input logic        sck,
    input logic        sdo,
    input logic        done,
    input logic [15:0] exp_word
);
    int checks = 0, fails = 0, frames = 0, dones = 0;
    int cs_low_cnt = 0, cs_high_cnt = 1000, hi_cnt = 0, lo_cnt = 1000;
    int since_fall = 0, stable_prev = 1000, nbits = 0;
    logic [15:0] sh = '0;
    bit prev_cs = 1'b1, prev_sck = IDLE_HIGH, prev_sdo = 1'b0, idle_bad = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", NAME, req, act, exp);
        end
    endtask

    always @(negedge clk) if (en) begin
        if (prev_cs && !cs_n) begin
            chk(cs_high_cnt >= 20, "R7 cs high time (cycles)", cs_high_cnt, 20);
            chk(!idle_bad, "R9 sck at idle level while deselected", int'(idle_bad), 0);
            nbits = 0; cs_low_cnt = 0; idle_bad = 1'b0;
        end
        if (!cs_n && prev_sck && !sck) begin
            chk(stable_prev >= 8, "R3 data setup before fall (cycles)", stable_prev, 8);
            chk(hi_cnt >= 8, "R4 high phase (cycles)", hi_cnt, 8);
            if (nbits == 0)
                chk(cs_low_cnt >= 5, "R5 cs setup to first fall (cycles)", cs_low_cnt, 5);
            else
                chk(since_fall >= 20, "R4 fall-to-fall period (cycles)", since_fall, 20);
            sh = {sh[14:0], prev_sdo};
            nbits++;
            since_fall = 0;
        end
        if (!cs_n && !prev_cs && !prev_sck && sck)
            chk(lo_cnt >= 8, "R4 low phase (cycles)", lo_cnt, 8);
        if (!prev_cs && cs_n) begin
            frames++;
            chk(nbits == 16, "R2 falling edges per frame", nbits, 16);
            chk(sh == exp_word, "R2 decoded word", int'(sh), int'(exp_word));
            chk(since_fall >= 10, "R6 last fall to cs rise (cycles)", since_fall, 10);
            cs_high_cnt = 0;
        end
        if (cs_n && sck != IDLE_HIGH) idle_bad = 1'b1;
        if (done) begin
            dones++;
            chk(cs_n && cs_high_cnt >= 20, "R7 done after cs high time", cs_high_cnt, 20);
        end
        hi_cnt      = sck ? hi_cnt + 1 : 0;
        lo_cnt      = sck ? 0 : lo_cnt + 1;
        stable_prev = (sdo == prev_sdo) ? stable_prev + 1 : 1;
        since_fall++;
        if (cs_n) cs_high_cnt++; else cs_low_cnt++;
        prev_cs = cs_n; prev_sck = sck; prev_sdo = sdo;
    end
endmodule

module dac_cmd_spi_host_tb;
    logic clk = 1'b0;
    logic rst_n;
    logic req_valid = 1'b0;
    logic [3:0] req_op = '0;
    logic [9:0] req_code = '0;
    logic [15:0] exp_word = '0;
    logic rdy_a, cs_a, sck_a, sdo_a, done_a;
    logic rdy_b, cs_b, sck_b, sdo_b, done_b;
    int checks = 0, failures = 0, sent = 0, cyc = 0;
    bit reported = 1'b0;

    always #2.5 clk = ~clk;

    dac_cmd_spi_host #(.IDLE_HIGH(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy_a),
        .req_op(req_op), .req_code(req_code), .spi_cs_n(cs_a), .spi_sck(sck_a),
        .spi_sdo(sdo_a), .done(done_a));

    dac_cmd_spi_host #(.IDLE_HIGH(1'b1)) u_dut_ih (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy_b),
        .req_op(req_op), .req_code(req_code), .spi_cs_n(cs_b), .spi_sck(sck_b),
        .spi_sdo(sdo_b), .done(done_b));

    dsh_rx_mon #(.IDLE_HIGH(1'b0), .NAME("idle_low")) u_mon_a (
        .clk(clk), .en(rst_n), .cs_n(cs_a), .sck(sck_a), .sdo(sdo_a),
        .done(done_a), .exp_word(exp_word));

    dsh_rx_mon #(.IDLE_HIGH(1'b1), .NAME("idle_high")) u_mon_b (
        .clk(clk), .en(rst_n), .cs_n(cs_b), .sck(sck_b), .sdo(sdo_b),
        .done(done_b), .exp_word(exp_word));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL bench %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d",
                     checks + u_mon_a.checks + u_mon_b.checks,
                     failures + u_mon_a.fails + u_mon_b.fails);
        end
    endtask

    task automatic send(input logic [3:0] op, input logic [9:0] code);
        while (!(rdy_a && rdy_b)) @(negedge clk);
        req_valid = 1'b1; req_op = op; req_code = code;
        exp_word  = {op, code, 2'b00};
        sent++;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (!(rdy_a && rdy_b)) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000 && !reported) begin
            failures++;
            $display("FAIL bench watchdog expired actual=%0d expected=%0d", cyc, 190000);
            report();
            $finish;
        end
    end

    initial begin
        logic [9:0] codes [8];
        codes = '{10'h000, 10'h001, 10'h3FF, 10'h200, 10'h1FF, 10'h155, 10'h2AA, 10'h0F0};
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        // R1: held in reset
        chk(cs_a && cs_b, "R1 cs_n high in reset", int'(cs_a && cs_b), 1);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 / R9: first cycle after release
        chk(cs_a == 1'b1 && cs_b == 1'b1, "R1 cs_n high after reset", int'(cs_a & cs_b), 1);
        chk(rdy_a && rdy_b, "R1 ready high after reset", int'(rdy_a & rdy_b), 1);
        chk(!done_a && !done_b, "R1 done low after reset", int'(done_a | done_b), 0);
        chk(sck_a == 1'b0, "R9 idle-low sck level", int'(sck_a), 0);
        chk(sck_b == 1'b1, "R9 idle-high sck level", int'(sck_b), 1);

        // R2..R7: every opcode against boundary and pattern codes
        for (int op = 0; op < 16; op++)
            for (int c = 0; c < 8; c++)
                send(4'(op), codes[c]);

        // R2: walking one through the code field
        for (int b = 0; b < 10; b++) send(4'h6, 10'(1 << b));

        // R8: request inputs change and valid stays high during a frame
        wait_idle();
        send(4'h3, 10'h2C5);
        chk(!rdy_a && !rdy_b, "R8 ready low while busy", int'(rdy_a | rdy_b), 0);
        req_valid = 1'b1; req_op = 4'hC; req_code = 10'h13A;
        repeat (40) @(negedge clk);
        chk(!rdy_a && !rdy_b, "R8 ready still low mid-frame", int'(rdy_a | rdy_b), 0);
        req_valid = 1'b0;
        wait_idle();
        chk(u_mon_a.frames == sent, "R8 idle-low frame count", u_mon_a.frames, sent);
        chk(u_mon_b.frames == sent, "R8 idle-high frame count", u_mon_b.frames, sent);
        chk(u_mon_a.dones == sent, "R7 idle-low done pulses", u_mon_a.dones, sent);
        chk(u_mon_b.dones == sent, "R7 idle-high done pulses", u_mon_b.dones, sent);
        chk(cs_a && cs_b && rdy_a && rdy_b, "R1 back at rest at end",
            int'(cs_a & cs_b & rdy_a & rdy_b), 1);

        report();
        $finish;
    end
endmodule